// File: doc/BRIEF.md
# Software trap entry and return controller

This block manages the status and return state of a small 32-bit core when software raises a trap. A trap request carries a trap number (one of sixteen) and the address of the trapping instruction. In a single clock edge, the block does four things:

- it copies the live supervisor, interrupt-enable and carry status bits into their backup copies;
- it clears interrupt-enable and carry, and leaves supervisor as it was;
- it stores the trap address plus four as the return address;
- it issues a fetch redirect to that trap's handler vector.

A return request reverses the status change. It copies the backup bits back into the live bits and redirects fetch to the stored return address, rounded down to a word boundary.

A trap at a halfword address still stores the address plus four. Bit 1 of the stored return address therefore records the alignment of the trap. Because the return path rounds down, both a word-aligned trap and the halfword trap that follows it resume at the same word. The core can also write the live status bits directly through a plain status write port. That write has the lowest priority.

Top module: `trap_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all live status bits, all backup bits, `bpc`, `redir_valid` and `proto_err` become 0.
- R2: On a trap edge, `bk_sm`, `bk_ie` and `bk_c` take the values that `st_sm`, `st_ie` and `st_c` had before that edge.
- R3: On a trap edge, `st_ie` and `st_c` become 0 and `st_sm` keeps its value.
- R4: On a trap edge, `bpc` becomes `trap_pc + 4`, taken modulo 2^32. A trap at 0x04 gives 0x08, and a trap at 0x06 gives 0x0A, so `bpc[1]` is 1 exactly for halfword-aligned traps.
- R5: After a trap edge, `redir_valid` is 1 for that one cycle and `redir_pc` equals `VEC_BASE + 4*trap_num`, with `VEC_BASE` defaulting to 0x40. Trap 15 therefore vectors to 0x7C.
- R6: On a return edge with no trap, the live status bits take the backup bit values, while the backup bits and `bpc` stay unchanged.
- R7: After a return edge with no trap, `redir_valid` is 1 for one cycle and `redir_pc` equals `bpc` with bits [1:0] forced to 00. Traps at 0x04 and 0x06 both resume at 0x08.
- R8: When a trap and a return are requested in the same cycle, the trap is performed (R2 to R5) and `proto_err` is 1 for the following cycle only. At all other times it is 0.
- R9: A status write (`st_wr`), with `st_wdata` laid out as [2]=supervisor, [1]=interrupt enable, [0]=carry, loads the live bits only in a cycle with no trap and no return. In any other cycle it is ignored.
- R10: In a cycle with no request and no write, `redir_valid` is 0 afterwards and all live bits, backup bits and `bpc` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap instruction issues this cycle |
| trap_num | input | 4 | Trap number 0..15 |
| trap_pc | input | 32 | Address of the trap instruction |
| rte_req | input | 1 | Return-from-exception issues this cycle |
| st_wr | input | 1 | Direct write of live status bits |
| st_wdata | input | 3 | Status write data {sm, ie, c} |
| st_sm | output | 1 | Live supervisor bit |
| st_ie | output | 1 | Live interrupt-enable bit |
| st_c | output | 1 | Live carry bit |
| bk_sm | output | 1 | Backup supervisor bit |
| bk_ie | output | 1 | Backup interrupt-enable bit |
| bk_c | output | 1 | Backup carry bit |
| bpc | output | 32 | Backup (return) address |
| redir_pc | output | 32 | Fetch redirect target |
| redir_valid | output | 1 | Redirect target valid, one cycle |
| proto_err | output | 1 | Trap and return collided last cycle |

## Verification
Every cycle, the assertions check the following behaviours:

- the status save and clear on trap entry;
- the trap-plus-four return address;
- the word-aligned return target;
- the single-cycle redirect strobe;
- the collision flag;
- the idle hold.

The exact handler addresses for each trap number need the bench scenarios, because a property cannot tie them to concrete values the way a scenario can. The same holds for the two example traps that resume at 0x08, the priority of a trap over a return and over a status write, and the wrap of the return address at the top of the address space. The bench compares against its reference model on every clock, over directed sequences and a long pseudo-random mix.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int AW = 32,
  parameter int NVEC = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h40,
  localparam int NW = $clog2(NVEC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap_req,
  input  logic [NW-1:0] trap_num,
  input  logic [AW-1:0] trap_pc,
  input  logic          rte_req,
  input  logic          st_wr,
  input  logic [2:0]    st_wdata,
  output logic          st_sm,
  output logic          st_ie,
  output logic          st_c,
  output logic          bk_sm,
  output logic          bk_ie,
  output logic          bk_c,
  output logic [AW-1:0] bpc,
  output logic [AW-1:0] redir_pc,
  output logic          redir_valid,
  output logic          proto_err
);

  logic          do_rte;
  logic [AW-1:0] vec_addr;

  assign do_rte   = rte_req && !trap_req;
  assign vec_addr = VEC_BASE + (AW'(trap_num) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      {st_sm, st_ie, st_c} <= 3'b000;
      {bk_sm, bk_ie, bk_c} <= 3'b000;
      bpc         <= '0;
      redir_pc    <= '0;
      redir_valid <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      redir_valid <= trap_req || rte_req;
      proto_err   <= trap_req && rte_req;
      if (trap_req) begin
        {bk_sm, bk_ie, bk_c} <= {st_sm, st_ie, st_c};
        st_ie    <= 1'b0;
        st_c     <= 1'b0;
        bpc      <= trap_pc + AW'(4);
        redir_pc <= vec_addr;
      end else if (do_rte) begin
        {st_sm, st_ie, st_c} <= {bk_sm, bk_ie, bk_c};
        redir_pc <= {bpc[AW-1:2], 2'b00};
      end else if (st_wr) begin
        {st_sm, st_ie, st_c} <= st_wdata;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> !redir_valid && !proto_err && bpc == '0 && {st_sm, st_ie, st_c, bk_sm, bk_ie, bk_c} == 6'b0);

  p_backup_r2: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> {bk_sm, bk_ie, bk_c} == $past({st_sm, st_ie, st_c}));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> !st_ie && !st_c && st_sm == $past(st_sm));

  p_retaddr_r4: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> bpc == $past(trap_pc) + AW'(4) && bpc[1] == $past(trap_pc[1]));

  p_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (trap_req || rte_req) |=> redir_valid);

  p_rte_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (rte_req && !trap_req) |=> $stable(bpc) && $stable({bk_sm, bk_ie, bk_c}) &&
                               {st_sm, st_ie, st_c} == {bk_sm, bk_ie, bk_c});

  p_rte_align_r7: assert property (@(posedge clk) disable iff (rst)
    (rte_req && !trap_req) |=> redir_pc[1:0] == 2'b00 && redir_pc[AW-1:2] == bpc[AW-1:2]);

  p_collide_r8: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> redir_valid && !st_ie && !st_c);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && !rte_req && !st_wr) |=> !redir_valid && !proto_err && $stable(bpc) &&
      $stable({st_sm, st_ie, st_c, bk_sm, bk_ie, bk_c}));

endmodule

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 0, rst = 1;
  logic trap_req = 0, rte_req = 0, st_wr = 0;
  logic [3:0] trap_num = 0;
  logic [31:0] trap_pc = 0;
  logic [2:0] st_wdata = 0;
  logic st_sm, st_ie, st_c, bk_sm, bk_ie, bk_c, redir_valid, proto_err;
  logic [31:0] bpc, redir_pc;

  int checks = 0, errors = 0;
  bit m_sm, m_ie, m_c, m_bsm, m_bie, m_bc, m_rv, m_err;
  logic [31:0] m_bpc, m_rpc;

  always #5 clk = ~clk;

  trap_ctrl uut (.clk, .rst, .trap_req, .trap_num, .trap_pc, .rte_req, .st_wr, .st_wdata,
    .st_sm, .st_ie, .st_c, .bk_sm, .bk_ie, .bk_c, .bpc, .redir_pc, .redir_valid, .proto_err);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(bit t, logic [3:0] n, logic [31:0] p, bit r, bit w, logic [2:0] wd);
    string tag;
    trap_req = t; trap_num = n; trap_pc = p; rte_req = r; st_wr = w; st_wdata = wd;
    m_rv = t | r; m_err = t & r;
    if (t) begin
      tag = r ? "R8" : "R2 R3 R4 R5";
      {m_bsm, m_bie, m_bc} = {m_sm, m_ie, m_c};
      m_ie = 0; m_c = 0;
      m_bpc = p + 32'd4;
      m_rpc = BASE + 32'(n) * 4;
    end else if (r) begin
      tag = "R6 R7";
      {m_sm, m_ie, m_c} = {m_bsm, m_bie, m_bc};
      m_rpc = {m_bpc[31:2], 2'b00};
    end else if (w) begin
      tag = "R9";
      {m_sm, m_ie, m_c} = wd;
    end else tag = "R10";
    @(posedge clk); #2;
    trap_req = 0; rte_req = 0; st_wr = 0;
    chk(tag, {29'd0, st_sm, st_ie, st_c}, {29'd0, m_sm, m_ie, m_c});
    chk(tag, {29'd0, bk_sm, bk_ie, bk_c}, {29'd0, m_bsm, m_bie, m_bc});
    chk(tag, bpc, m_bpc);
    chk(tag, {30'd0, redir_valid, proto_err}, {30'd0, m_rv, m_err});
    if (m_rv) chk(tag, redir_pc, m_rpc);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R1", {26'd0, st_sm, st_ie, st_c, bk_sm, bk_ie, bk_c}, 32'd0);
    chk("R1", bpc, 32'd0);
    chk("R1", {30'd0, redir_valid, proto_err}, 32'd0);
    rst = 0;
    m_bpc = 0; m_rpc = 0;

    tick(0, 0, 0, 0, 1, 3'b111);
    chk("R9", {29'd0, st_sm, st_ie, st_c}, 32'd7);
    tick(1, 4'd0, 32'h4, 0, 0, 0);
    chk("R4", bpc, 32'h8);
    chk("R5", redir_pc, 32'h40);
    chk("R3", {29'd0, st_sm, st_ie, st_c}, 32'd4);
    chk("R2", {29'd0, bk_sm, bk_ie, bk_c}, 32'd7);
    tick(0, 0, 0, 0, 0, 0);
    chk("R5", {31'd0, redir_valid}, 32'd0);
    tick(0, 0, 0, 1, 0, 0);
    chk("R7", redir_pc, 32'h8);
    chk("R6", {29'd0, st_sm, st_ie, st_c}, 32'd7);
    tick(1, 4'd15, 32'h6, 0, 0, 0);
    chk("R4", bpc, 32'hA);
    chk("R5", redir_pc, 32'h7C);
    tick(0, 0, 0, 1, 1, 3'b000);
    chk("R7", redir_pc, 32'h8);
    chk("R9", {29'd0, st_sm, st_ie, st_c}, 32'd7);
    tick(1, 4'd3, 32'h100, 1, 1, 3'b010);
    chk("R8", {31'd0, proto_err}, 32'd1);
    chk("R8", redir_pc, 32'h4C);
    tick(0, 0, 0, 0, 0, 0);
    chk("R8", {31'd0, proto_err}, 32'd0);
    tick(1, 4'd1, 32'hFFFF_FFFE, 0, 0, 0);
    chk("R4", bpc, 32'h2);

    for (int i = 0; i < 2000; i++) begin
      int k = $urandom_range(0, 9);
      tick(k < 3, 4'($urandom), $urandom, k >= 2 && k < 5, k >= 4 && k < 8, 3'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule